// File: doc/BRIEF.md
# Programmable Low-Power Mode Sequencer

This block is a per-core power controller. Software loads a short program of one-byte steps into a local 64-entry sequence memory. It then picks a low-power mode by writing a start index and an enable bit into a control register. When the core's wait-for-interrupt signal rises, the controller runs the program from that index.

Each step does one of four things. It can drive the power-control outputs: core clock gate, core supply, core reset and cache standby request. It can stall until a wake-up interrupt or a cache-ready acknowledge arrives. It can stall for one of three programmed cycle counts. Or it can end the sequence, which hands the core back with every output at its run value. Different modes share the one memory and differ only in where they start. A standby program and a standalone power-down program can therefore sit side by side. Progress and the last finished mode can be read from a status register.

Top module: `pwrseq_top`

## Requirements
- R1: After reset the core clock runs (`core_clk_gate`=0), the supply is on (`core_pwr_en`=1), `core_reset`=0 and `cache_stby`=0. The status register reads busy 0, program counter 0 and last index 0.
- R2: Register map:
  - 0x08 is a 32-bit read/write configuration word.
  - 0x30 is control: enable in bit 0, 7-bit start index in bits 10:4, all other bits read 0. A write loads both fields.
  - 0x34 holds three 10-bit delay counts in bits 9:0, 19:10 and 29:20, with bits 31:30 reading 0.
  - 0x0C is read-only status: busy in bit 0, program counter in bits 9:4, last completed start index in bits 22:16.
  - Writes to any other address, including unaligned ones, change nothing.
- R3: The sequence memory holds 64 bytes. The 32-bit word at 0x80+4k holds entries 4k (bits 7:0) through 4k+3 (bits 31:24), and the word reads back as written.
- R4: A sequence starts only when the block is idle, enable is set and `core_wfi` is high after being low on the previous clock. Execution begins at the start index modulo 64. With enable clear, nothing runs.
- R5: A step whose bits 7:6 are 00 loads its bits 3:0 into the outputs on the following clock. The bits are: bit 0 gates the clock, bit 1 removes the supply, bit 2 asserts core reset, bit 3 requests cache standby.
- R6: `cache_stby` is high only while `all_idle` is high, even when the program requests standby.
- R7: A step with bits 7:6 = 01 stalls until its event is high. Event select 0 (bits 1:0) is `wake_irq`, 1 is `cache_rdy`, and other values do not stall. If the event is already high, the step finishes at once and the following steps still run in order.
- R8: A step with bits 7:6 = 10 stalls for N extra clocks, where N is the delay field picked by bits 1:0 (0, 1, 2). Select 3 gives N = 0.
- R9: A step with bits 7:6 = 11 ends the sequence. On the same clock the outputs return to their run values, busy clears and the start index is recorded as the last completed index.
- R10: After a sequence ends, `core_wfi` must fall and rise again before another sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| core_wfi | input | 1 | Core wait-for-interrupt indication |
| wake_irq | input | 1 | Wake-up interrupt pending |
| cache_rdy | input | 1 | Cache/system ready acknowledge |
| all_idle | input | 1 | All cores idle, permits cache standby |
| core_clk_gate | output | 1 | Gate the core clock |
| core_pwr_en | output | 1 | Core supply enable |
| core_reset | output | 1 | Core reset (warm boot) |
| cache_stby | output | 1 | Cache standby request |

## Verification
The hardest case to reach is a mode entered while the wake-up and cache-ready events are already high. In that case the wait steps must fall straight through, yet every drive step must still take effect, in order and for exactly one clock. The bench raises both events before it raises `core_wfi`. It then counts the clocks for which the clock gate is high and compares that count with the number of steps. Delay lengths are checked the same way, by counting how long an output stays high. The bench also measures the reset pulse of the power-down program, which must last exactly one delay field plus two clocks.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    OP_DRIVE = 2'b00,
    OP_WAIT  = 2'b01,
    OP_DELAY = 2'b10,
    OP_END   = 2'b11
  } op_e;

  typedef struct packed {
    logic stby;
    logic rst;
    logic pwr_off;
    logic gate;
  } pout_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DLY} st_e;

  localparam int ADR_CFG  = 'h08;
  localparam int ADR_STAT = 'h0C;
  localparam int ADR_CTL  = 'h30;
  localparam int ADR_DLY  = 'h34;
  localparam int ADR_SEQ  = 'h80;
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEQ_DEPTH = 64,
  parameter int IDX_W     = 7,
  parameter int DLY_W     = 10,
  parameter int NUM_DLY   = 3,
  localparam int PC_W     = $clog2(SEQ_DEPTH),
  localparam int WORDS    = SEQ_DEPTH / 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [PC_W-1:0]          rd_pc,
  output logic [7:0]               rd_op,
  output logic                     ctl_en,
  output logic [IDX_W-1:0]         ctl_idx,
  output logic [NUM_DLY*DLY_W-1:0] dly_cfg,
  input  logic                     busy,
  input  logic [IDX_W-1:0]         last_idx
);
  logic [7:0]  mem [SEQ_DEPTH];
  logic [31:0] cfg_q;
  logic        cfg_we, ctl_we, dly_we;

  assign cfg_we = bus_wr && (bus_addr == ADDR_W'(ADR_CFG));
  assign ctl_we = bus_wr && (bus_addr == ADDR_W'(ADR_CTL));
  assign dly_we = bus_wr && (bus_addr == ADDR_W'(ADR_DLY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      ctl_en  <= 1'b0;
      ctl_idx <= '0;
      dly_cfg <= '0;
    end else begin
      if (cfg_we) cfg_q <= bus_wdata;
      if (ctl_we) begin
        ctl_en  <= bus_wdata[0];
        ctl_idx <= bus_wdata[4 +: IDX_W];
      end
      if (dly_we) dly_cfg <= bus_wdata[NUM_DLY*DLY_W-1:0];
    end
  end

  // sequence storage: RAM-like, no reset
  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (bus_wr && bus_addr == ADDR_W'(ADR_SEQ + 4 * w)) begin
        for (int b = 0; b < 4; b++) mem[4*w+b] <= bus_wdata[8*b +: 8];
      end
    end
  end

  assign rd_op = mem[rd_pc];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CFG)) bus_rdata = cfg_q;
    if (bus_addr == ADDR_W'(ADR_CTL)) bus_rdata[4 +: IDX_W] = ctl_idx;
    if (bus_addr == ADDR_W'(ADR_CTL)) bus_rdata[0] = ctl_en;
    if (bus_addr == ADDR_W'(ADR_DLY)) bus_rdata[NUM_DLY*DLY_W-1:0] = dly_cfg;
    if (bus_addr == ADDR_W'(ADR_STAT)) begin
      bus_rdata[0]            = busy;
      bus_rdata[4 +: PC_W]    = rd_pc;
      bus_rdata[16 +: IDX_W]  = last_idx;
    end
    for (int w = 0; w < WORDS; w++) begin
      if (bus_addr == ADDR_W'(ADR_SEQ + 4 * w))
        bus_rdata = {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
    end
  end
endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
  import pwrseq_pkg::*;
#(
  parameter int SEQ_DEPTH = 64,
  parameter int IDX_W     = 7,
  parameter int DLY_W     = 10,
  parameter int NUM_DLY   = 3,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_en,
  input  logic [IDX_W-1:0]         ctl_idx,
  input  logic [NUM_DLY*DLY_W-1:0] dly_cfg,
  input  logic [7:0]               op,
  input  logic                     core_wfi,
  input  logic                     wake_irq,
  input  logic                     cache_rdy,
  output logic [PC_W-1:0]          pc,
  output logic                     busy,
  output logic [IDX_W-1:0]         last_idx,
  output pout_t                    outs
);
  st_e              st, st_n;
  logic [PC_W-1:0]  pc_n;
  logic [DLY_W-1:0] cnt, cnt_n, dly_pick;
  logic [IDX_W-1:0] run_idx, run_idx_n, last_n;
  pout_t            outs_n;
  logic             wfi_q, ev_hit;
  op_e              typ;
  logic [1:0]       sel;
  logic [1:0]       unused_op_bits;

  assign typ            = op_e'(op[7:6]);
  assign sel            = op[1:0];
  assign unused_op_bits = op[5:4];
  assign busy           = (st != S_IDLE);

  always_comb begin
    dly_pick = '0;
    if (int'(sel) < NUM_DLY) dly_pick = dly_cfg[int'(sel)*DLY_W +: DLY_W];
    case (sel)
      2'd0:    ev_hit = wake_irq;
      2'd1:    ev_hit = cache_rdy;
      default: ev_hit = 1'b1;
    endcase
  end

  always_comb begin
    st_n      = st;
    pc_n      = pc;
    cnt_n     = cnt;
    run_idx_n = run_idx;
    last_n    = last_idx;
    outs_n    = outs;
    case (st)
      S_IDLE: if (ctl_en && core_wfi && !wfi_q) begin
        st_n      = S_RUN;
        pc_n      = ctl_idx[PC_W-1:0];
        run_idx_n = ctl_idx;
      end
      S_RUN: case (typ)
        OP_DRIVE: begin
          outs_n = pout_t'(op[3:0]);
          pc_n   = pc + 1'b1;
        end
        OP_WAIT: if (ev_hit) pc_n = pc + 1'b1;
        OP_DELAY: begin
          if (dly_pick == '0) pc_n = pc + 1'b1;
          else begin
            cnt_n = dly_pick - 1'b1;
            st_n  = S_DLY;
          end
        end
        default: begin
          st_n   = S_IDLE;
          outs_n = '0;
          last_n = run_idx;
        end
      endcase
      default: begin
        if (cnt == '0) begin
          pc_n = pc + 1'b1;
          st_n = S_RUN;
        end else cnt_n = cnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pc       <= '0;
      cnt      <= '0;
      run_idx  <= '0;
      last_idx <= '0;
      outs     <= '0;
      wfi_q    <= 1'b0;
    end else begin
      st       <= st_n;
      pc       <= pc_n;
      cnt      <= cnt_n;
      run_idx  <= run_idx_n;
      last_idx <= last_n;
      outs     <= outs_n;
      wfi_q    <= core_wfi;
    end
  end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SEQ_DEPTH = 64,
  parameter int IDX_W     = 7,
  parameter int DLY_W     = 10,
  parameter int NUM_DLY   = 3,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_wfi,
  input  logic              wake_irq,
  input  logic              cache_rdy,
  input  logic              all_idle,
  output logic              core_clk_gate,
  output logic              core_pwr_en,
  output logic              core_reset,
  output logic              cache_stby
);
  logic                     ctl_en;
  logic [IDX_W-1:0]         ctl_idx;
  logic [NUM_DLY*DLY_W-1:0] dly_cfg;
  logic [PC_W-1:0]          seq_pc;
  logic [7:0]               seq_op;
  logic                     seq_busy;
  logic [IDX_W-1:0]         last_idx;
  pout_t                    outs;

  pwrseq_regs #(
    .ADDR_W(ADDR_W), .SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W),
    .DLY_W(DLY_W), .NUM_DLY(NUM_DLY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_pc(seq_pc),
    .rd_op(seq_op), .ctl_en(ctl_en), .ctl_idx(ctl_idx), .dly_cfg(dly_cfg),
    .busy(seq_busy), .last_idx(last_idx)
  );

  pwrseq_engine #(
    .SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W), .DLY_W(DLY_W), .NUM_DLY(NUM_DLY)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_idx(ctl_idx),
    .dly_cfg(dly_cfg), .op(seq_op), .core_wfi(core_wfi),
    .wake_irq(wake_irq), .cache_rdy(cache_rdy), .pc(seq_pc),
    .busy(seq_busy), .last_idx(last_idx), .outs(outs)
  );

  assign core_clk_gate = outs.gate;
  assign core_pwr_en   = !outs.pwr_off;
  assign core_reset    = outs.rst;
  assign cache_stby    = outs.stby && all_idle;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int ADDR_W    = 8,
  parameter int SEQ_DEPTH = 64,
  parameter int IDX_W     = 7,
  parameter int DLY_W     = 10,
  parameter int NUM_DLY   = 3,
  localparam int PC_W     = $clog2(SEQ_DEPTH)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     core_wfi,
  input logic                     wake_irq,
  input logic                     all_idle,
  input logic                     core_clk_gate,
  input logic                     core_pwr_en,
  input logic                     core_reset,
  input logic                     cache_stby,
  input logic                     seq_busy,
  input logic [PC_W-1:0]          seq_pc,
  input logic [7:0]               seq_op,
  input logic                     ctl_en,
  input logic [IDX_W-1:0]         ctl_idx,
  input logic [NUM_DLY*DLY_W-1:0] dly_cfg
);
  logic wfi_seen;
  logic unmapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wfi_seen <= 1'b0;
    else        wfi_seen <= core_wfi;
  end

  assign unmapped = !(bus_addr == 8'h08 || bus_addr == 8'h30 || bus_addr == 8'h34 ||
                      (int'(bus_addr) >= 'h80 && int'(bus_addr) < 'h80 + SEQ_DEPTH &&
                       bus_addr[1:0] == 2'b00));

  assert_idle_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (core_pwr_en && !core_clk_gate && !core_reset && !cache_stby));

  assert_stby_needs_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cache_stby |-> all_idle);

  assert_start_on_wfi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && ctl_en && core_wfi && !wfi_seen) |=> seq_busy);

  assert_no_start_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_busy && !ctl_en) |=> !seq_busy);

  assert_unmapped_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unmapped) |=> ($stable(ctl_en) && $stable(ctl_idx) && $stable(dly_cfg)));

  assert_wait_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && seq_op[7:6] == 2'b01 && seq_op[1:0] == 2'b00 && !wake_irq &&
     !(bus_wr && !unmapped)) |=> $stable(seq_pc));
endmodule

bind pwrseq_top pwrseq_chk #(
  .ADDR_W(ADDR_W), .SEQ_DEPTH(SEQ_DEPTH), .IDX_W(IDX_W),
  .DLY_W(DLY_W), .NUM_DLY(NUM_DLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .core_wfi(core_wfi), .wake_irq(wake_irq), .all_idle(all_idle),
  .core_clk_gate(core_clk_gate), .core_pwr_en(core_pwr_en),
  .core_reset(core_reset), .cache_stby(cache_stby), .seq_busy(seq_busy),
  .seq_pc(seq_pc), .seq_op(seq_op), .ctl_en(ctl_en), .ctl_idx(ctl_idx),
  .dly_cfg(dly_cfg)
);

// File: tb/sim_pwrseq_top.sv
module sim_pwrseq_top;
  logic        clk, rst_n, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, rd;
  logic        core_wfi, wake_irq, cache_rdy, all_idle;
  logic        core_clk_gate, core_pwr_en, core_reset, cache_stby;
  int          n_chk, n_err, cnt;
  bit          done;

  pwrseq_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_wfi(core_wfi),
    .wake_irq(wake_irq), .cache_rdy(cache_rdy), .all_idle(all_idle),
    .core_clk_gate(core_clk_gate), .core_pwr_en(core_pwr_en),
    .core_reset(core_reset), .cache_stby(cache_stby)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {write addr, write data, read addr, expected read}
  localparam logic [79:0] VEC [0:7] = '{
    {8'h08, 32'hDEADBEEF, 8'h08, 32'hDEADBEEF},
    {8'h30, 32'hFFFFFFFF, 8'h30, 32'h000007F1},
    {8'h30, 32'h00000000, 8'h30, 32'h00000000},
    {8'h34, 32'hFFFFFFFF, 8'h34, 32'h3FFFFFFF},
    {8'h0C, 32'hFFFFFFFF, 8'h0C, 32'h00000000},
    {8'h44, 32'h12345678, 8'h08, 32'hDEADBEEF},
    {8'h84, 32'h11223344, 8'h84, 32'h11223344},
    {8'h86, 32'h55667788, 8'h84, 32'h11223344}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_wfi();
    @(negedge clk); core_wfi = 1'b0;
    @(negedge clk); core_wfi = 1'b1;
  endtask

  // count negedges with the selected output high: 0 gate, 1 reset
  task automatic count_high(input int which, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((which == 0) ? core_clk_gate : core_reset) c++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    core_wfi = 0; wake_irq = 0; cache_rdy = 0; all_idle = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 gate", {31'd0, core_clk_gate}, 0);
    chk("R1 pwr", {31'd0, core_pwr_en}, 1);
    chk("R1 rst", {31'd0, core_reset}, 0);
    chk("R1 stby", {31'd0, cache_stby}, 0);
    rdreg(8'h0C, rd); chk("R1 status", rd, 0);

    // register table: R2 map, R3 word packing
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][79:72], VEC[v][71:40]);
      rdreg(VEC[v][39:32], rd);
      chk((v >= 6) ? "R3 seq word" : "R2 regmap", rd, VEC[v][31:0]);
    end

    // programs: standby @0, power-down @8, delays @16 and @20
    wr(8'h80, 32'h41014009);
    wr(8'h84, 32'h000000C0);
    wr(8'h88, 32'h41014003);
    wr(8'h8C, 32'hC0008105);
    wr(8'h90, 32'h00C08001);
    wr(8'h94, 32'h00C08101);
    wr(8'h34, 32'h00701414);   // fields 20, 5, 7
    rdreg(8'h80, rd); chk("R3 readback", rd, 32'h41014009);

    // R4: disabled -> no run
    wr(8'h30, 32'h00000000);
    pulse_wfi();
    count_high(0, 10, cnt); chk("R4 disabled", cnt, 0);
    rdreg(8'h0C, rd); chk("R4 disabled busy", {31'd0, rd[0]}, 0);

    // standby program
    core_wfi = 0;
    wr(8'h30, 32'h00000001);
    pulse_wfi();
    repeat (6) @(negedge clk);
    chk("R5 gate", {31'd0, core_clk_gate}, 1);
    chk("R5 stby", {31'd0, cache_stby}, 1);
    rdreg(8'h0C, rd);
    chk("R7 stalled pc", {26'd0, rd[9:4]}, 1);
    chk("R7 busy", {31'd0, rd[0]}, 1);
    wake_irq = 1;
    repeat (6) @(negedge clk);
    chk("R5 stby dropped", {31'd0, cache_stby}, 0);
    chk("R7 gate held", {31'd0, core_clk_gate}, 1);
    rdreg(8'h0C, rd); chk("R7 cache wait pc", {26'd0, rd[9:4]}, 3);
    cache_rdy = 1;
    repeat (4) @(negedge clk);
    chk("R9 gate released", {31'd0, core_clk_gate}, 0);
    rdreg(8'h0C, rd);
    chk("R9 idle", {31'd0, rd[0]}, 0);
    chk("R9 last idx", {25'd0, rd[22:16]}, 0);
    wake_irq = 0; cache_rdy = 0;

    // R10: wfi held high, no restart
    count_high(0, 10, cnt); chk("R10 no restart", cnt, 0);

    // R6: standby with all_idle low
    all_idle = 0;
    pulse_wfi();
    repeat (6) @(negedge clk);
    chk("R6 gate", {31'd0, core_clk_gate}, 1);
    chk("R6 stby blocked", {31'd0, cache_stby}, 0);
    wake_irq = 1; cache_rdy = 1;
    repeat (6) @(negedge clk);
    wake_irq = 0; cache_rdy = 0;

    // power-down program at 8
    wr(8'h30, 32'h00000081);
    pulse_wfi();
    repeat (6) @(negedge clk);
    chk("R5 supply off", {31'd0, core_pwr_en}, 0);
    rdreg(8'h0C, rd); chk("R7 pd wait pc", {26'd0, rd[9:4]}, 9);
    wake_irq = 1;
    repeat (6) @(negedge clk);
    chk("R5 supply back", {31'd0, core_pwr_en}, 1);
    rdreg(8'h0C, rd); chk("R7 pd ready pc", {26'd0, rd[9:4]}, 11);
    cache_rdy = 1;
    count_high(1, 30, cnt); chk("R8 reset pulse sel1", cnt, 7);
    rdreg(8'h0C, rd);
    chk("R9 pd last idx", {25'd0, rd[22:16]}, 8);
    chk("R9 pd idle", {31'd0, rd[0]}, 0);
    wake_irq = 0; cache_rdy = 0; all_idle = 1;

    // R8: delay lengths
    wr(8'h30, 32'h00000101);
    pulse_wfi();
    count_high(0, 50, cnt); chk("R8 delay sel0", cnt, 22);
    wr(8'h30, 32'h00000141);
    pulse_wfi();
    count_high(0, 30, cnt); chk("R8 delay sel1", cnt, 7);

    // R7: events pending at start, steps still run in order
    wake_irq = 1; cache_rdy = 1;
    wr(8'h30, 32'h00000001);
    pulse_wfi();
    count_high(0, 20, cnt); chk("R7 pending run", cnt, 4);
    rdreg(8'h0C, rd); chk("R7 pending last", {25'd0, rd[22:16]}, 0);
    wake_irq = 0; cache_rdy = 0;

    // reset mid-sequence returns to R1 state
    pulse_wfi();
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid reset gate", {31'd0, core_clk_gate}, 0);
    rst_n = 1;
    rdreg(8'h30, rd); chk("R1 ctl cleared", rd, 0);
    finish_run();
  end
endmodule